// File: doc/BRIEF.md
# Register-by-Memory Dot Product Sequencer

The sequencer forms the inner product of two vectors of signed 16-bit elements. One vector sits in a bank of 32-bit registers, two elements per register. The other vector is fetched from memory one 16-bit word at a time. A single start pulse captures a control word, a memory pointer, a source register base and a destination register index. The block then steps through the elements and sums the signed products in a wide accumulator. At the end it delivers the low 32 bits of that sum as a one-cycle write-back to the destination register.

The control word packs the element count into its low four bits. Bit 4 chooses how memory is walked. With bit 4 clear (row walk), consecutive elements are adjacent words. With bit 4 set (column walk), consecutive elements are separated by a stride of twice the element count in bytes, as when a column is read out of a row-major matrix whose rows are as long as the vector. The environment supplies the register bank as a combinational read port. Memory is reached through a request/valid read port that never has more than one read in flight.

Top module: `mdot_seq`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `mem_req`, `wb_en` and `done` are all low.
- R2: An operation started with element count N = `cfg_ctrl[3:0]` issues exactly N memory reads.
- R3: With `cfg_ctrl[4]` = 0 (row walk), read k (counting from 0) is at address `mem_ptr` + 2k. The first read request comes in the cycle after the accepted start.
- R4: With `cfg_ctrl[4]` = 1 (column walk), read k is at address `mem_ptr` + k·2N.
- R5: Element k of the register vector is taken from register (`src_base` + k/2) mod 32. It is bits [31:16] of that register when k is even and bits [15:0] when k is odd.
- R6: `wb_data` carries the low 32 bits of the sum over all k of signed(register element k) × signed(memory word k). The sum is formed without overflow for up to 15 terms.
- R7: A count of 0 issues no reads. It writes 0 in the cycle after the accepted start.
- R8: A new read request is never raised while an earlier read has not yet returned `mem_rvalid`.
- R9: Each operation gives exactly one single-cycle `wb_en` pulse, with `wb_idx` equal to the captured `dst_sel`. `done` pulses for one cycle in the cycle that follows it.
- R10: A `start` pulse, and any change of `cfg_ctrl`, `mem_ptr`, `src_base` or `dst_sel`, while `busy` is high has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| cfg_ctrl | input | 5 | Bits [3:0] element count, bit 4 column walk |
| mem_ptr | input | 32 | Byte address of the first memory element |
| src_base | input | 5 | First register of the register vector |
| dst_sel | input | 5 | Destination register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the write-back |
| rf_raddr | output | 5 | Register bank read address |
| rf_rdata | input | 32 | Register bank read data (combinational) |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| wb_en | output | 1 | Write-back strobe |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Write-back value |

## Verification
A fresh `start` can coincide with any cycle of a running operation, including the cycle in which the last read returns and the write-back cycle. The bench provokes this by holding `start` high for the whole run while it scrambles every configuration input. It then judges the result at the ports: the address sequence, the read count, the written value and the destination index must all match what the original configuration predicts. Read latencies from zero to three extra cycles also move the accumulate step relative to the request, and the one-outstanding-read rule is watched throughout.

// File: rtl/mdot_pkg.sv
package mdot_pkg;

    // architectural element and register word widths
    localparam int ELEM_W = 16;
    localparam int WORD_W = 2 * ELEM_W;
    localparam int PROD_W = 2 * ELEM_W;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ISSUE = 3'd1,
        S_WAIT  = 3'd2,
        S_WRITE = 3'd3,
        S_DONE  = 3'd4
    } seq_state_e;

    typedef logic signed [ELEM_W-1:0] elem_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    // signed 16x16 product
    function automatic prod_t elem_mul(input elem_t a, input elem_t b);
        return a * b;
    endfunction

endpackage

// File: rtl/mdot_ctrl.sv
module mdot_ctrl
    import mdot_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             rvalid,
    output logic             load,
    output logic             step,
    output logic             mem_req,
    output logic             wb_en,
    output logic             done,
    output logic             busy,
    output logic [CNT_W-1:0] idx
);

    seq_state_e       st_q, st_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign load    = (st_q == S_IDLE) && start;
    assign step    = (st_q == S_WAIT) && rvalid;
    assign last    = (idx == cnt_q - 1'b1);
    assign mem_req = (st_q == S_ISSUE);
    assign wb_en   = (st_q == S_WRITE);
    assign done    = (st_q == S_DONE);
    assign busy    = (st_q != S_IDLE);

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (start) st_nx = (count == '0) ? S_WRITE : S_ISSUE;
            end
            S_ISSUE: st_nx = S_WAIT;
            S_WAIT: begin
                if (rvalid) st_nx = last ? S_WRITE : S_ISSUE;
            end
            S_WRITE: st_nx = S_DONE;
            S_DONE:  st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            idx   <= '0;
        end else begin
            st_q <= st_nx;
            if (load) begin
                cnt_q <= count;
                idx   <= '0;
            end else if (step) begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mdot_addr_gen.sv
module mdot_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              col_mode,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] addr
);

    localparam int PAD_W = ADDR_W - CNT_W - 1;
    localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] stride_q;
    logic [ADDR_W-1:0] stride_in;

    // column walk: stride of twice the element count, in bytes
    assign stride_in = col_mode ? {{PAD_W{1'b0}}, count, 1'b0} : ROW_STEP;
    assign addr      = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            stride_q <= '0;
        end else if (load) begin
            cur_q    <= ptr;
            stride_q <= stride_in;
        end else if (step) begin
            cur_q <= cur_q + stride_q;
        end
    end

endmodule

// File: rtl/mdot_elem_sel.sv
module mdot_elem_sel
    import mdot_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [REG_AW-1:0] base,
    input  logic [CNT_W-1:0]  idx,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic [REG_AW-1:0] rf_raddr,
    output elem_t             elem
);

    logic [REG_AW-1:0] base_q;
    logic [CNT_W-1:0]  pair;

    assign pair     = idx >> 1;
    assign rf_raddr = base_q + REG_AW'(pair);
    // even element: upper half first
    assign elem     = idx[0] ? elem_t'(rf_rdata[ELEM_W-1:0])
                             : elem_t'(rf_rdata[WORD_W-1:ELEM_W]);

    always_ff @(posedge clk) begin
        if (rst) base_q <= '0;
        else if (load) base_q <= base;
    end

endmodule

// File: rtl/mdot_acc.sv
module mdot_acc
    import mdot_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  elem_t             reg_elem,
    input  elem_t             mem_elem,
    output logic [WORD_W-1:0] result
);

    localparam int EXT_W = ACC_W - PROD_W;

    prod_t             prod;
    logic [ACC_W-1:0]  prod_ext;
    logic [ACC_W-1:0]  acc_q;

    assign prod     = elem_mul(reg_elem, mem_elem);
    assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
    assign result   = acc_q[WORD_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clear) acc_q <= '0;
        else if (step) acc_q <= acc_q + prod_ext;
    end

endmodule

// File: rtl/mdot_seq.sv
module mdot_seq
    import mdot_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_AW = 5,
    parameter int CNT_W  = 4,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W:0]    cfg_ctrl,
    input  logic [ADDR_W-1:0] mem_ptr,
    input  logic [REG_AW-1:0] src_base,
    input  logic [REG_AW-1:0] dst_sel,
    output logic              busy,
    output logic              done,
    output logic [REG_AW-1:0] rf_raddr,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ELEM_W-1:0] mem_rdata,
    output logic              wb_en,
    output logic [REG_AW-1:0] wb_idx,
    output logic [WORD_W-1:0] wb_data
);

    logic             load, step;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] count;
    logic             col_mode;
    elem_t            reg_elem;
    logic [REG_AW-1:0] dst_q;

    assign count    = cfg_ctrl[CNT_W-1:0];
    assign col_mode = cfg_ctrl[CNT_W];
    assign wb_idx   = dst_q;

    mdot_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .count(count),
        .rvalid(mem_rvalid), .load(load), .step(step),
        .mem_req(mem_req), .wb_en(wb_en), .done(done), .busy(busy),
        .idx(idx)
    );

    mdot_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) addr_i (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .col_mode(col_mode), .count(count), .ptr(mem_ptr),
        .addr(mem_addr)
    );

    mdot_elem_sel #(.REG_AW(REG_AW), .CNT_W(CNT_W)) sel_i (
        .clk(clk), .rst(rst), .load(load), .base(src_base), .idx(idx),
        .rf_rdata(rf_rdata), .rf_raddr(rf_raddr), .elem(reg_elem)
    );

    mdot_acc #(.ACC_W(ACC_W)) acc_i (
        .clk(clk), .rst(rst), .clear(load), .step(step),
        .reg_elem(reg_elem), .mem_elem(elem_t'(mem_rdata)),
        .result(wb_data)
    );

    always_ff @(posedge clk) begin
        if (rst) dst_q <= '0;
        else if (load) dst_q <= dst_sel;
    end

endmodule

// File: rtl/mdot_seq_chk.sv
module mdot_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic [CNT_W:0]    cfg_ctrl,
    input logic [ADDR_W-1:0] mem_ptr,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              wb_en,
    input logic [31:0]       wb_data,
    input logic              done
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else if (mem_req) pend_q <= 1'b1;
        else if (mem_rvalid) pend_q <= 1'b0;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !wb_en && !done));

    // R8
    one_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !pend_q);

    // R9
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> done);

    // R9
    wb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> !wb_en);

    // R7
    zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_ctrl[CNT_W-1:0] == '0) |=> (wb_en && wb_data == 32'd0 && !mem_req));

    // R3
    first_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_ctrl[CNT_W-1:0] != '0) |=> (mem_req && mem_addr == $past(mem_ptr)));

endmodule

bind mdot_seq mdot_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .cfg_ctrl(cfg_ctrl),
    .mem_ptr(mem_ptr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .wb_en(wb_en), .wb_data(wb_data), .done(done)
);

// File: tb/mdot_seq_tb_top.sv
`timescale 1ns/1ps
module mdot_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  cfg_ctrl = '0;
    logic [31:0] mem_ptr = '0;
    logic [4:0]  src_base = '0;
    logic [4:0]  dst_sel = '0;
    logic        busy, done, mem_req, wb_en;
    logic [4:0]  rf_raddr, wb_idx;
    logic [31:0] rf_rdata, mem_addr, wb_data;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] memword(input logic [31:0] a);
        logic [31:0] t;
        t = (a * 32'h9e37) ^ 32'hc35a;
        return t[15:0];
    endfunction

    function automatic logic [31:0] rfval(input logic [4:0] r);
        logic [31:0] hi, lo;
        hi = {27'b0, r} * 32'h3b1d + 32'h8123;
        lo = ({27'b0, r} * 32'h2c49) ^ 32'h7e01;
        return {hi[15:0], lo[15:0]};
    endfunction

    assign rf_rdata = rfval(rf_raddr);

    mdot_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .cfg_ctrl(cfg_ctrl),
        .mem_ptr(mem_ptr), .src_base(src_base), .dst_sel(dst_sel),
        .busy(busy), .done(done), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    // memory responder and port monitor
    int          lat = 0;
    logic        pend = 1'b0;
    int          wcnt = 0;
    logic [31:0] paddr = '0;
    logic [31:0] addr_log [256];
    int          rd_n = 0, wb_n = 0, done_n = 0, bad_done = 0, overlap_n = 0;
    logic [31:0] wb_last = '0;
    logic [4:0]  wbi_last = '0;
    logic        prev_wb = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            mem_rvalid <= 1'b0;
            prev_wb    <= 1'b0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req) begin
                if (pend) overlap_n <= overlap_n + 1;
                pend  <= 1'b1;
                wcnt  <= lat;
                paddr <= mem_addr;
                addr_log[rd_n % 256] <= mem_addr;
                rd_n  <= rd_n + 1;
            end else if (pend) begin
                if (wcnt == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= memword(paddr);
                    pend       <= 1'b0;
                end else begin
                    wcnt <= wcnt - 1;
                end
            end
            if (wb_en) begin
                wb_n     <= wb_n + 1;
                wb_last  <= wb_data;
                wbi_last <= wb_idx;
            end
            prev_wb <= wb_en;
            if (done && !prev_wb) bad_done <= bad_done + 1;
            if (done) done_n <= done_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // fields: [33] column walk, [32:29] count, [28:24] base, [23:19] dest,
    //         [18:3] pointer, [2:1] extra read latency, [0] start held while busy
    localparam int NVEC = 8;
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b0, 4'd4,  5'd2,  5'd3,  16'h0100, 2'd0, 1'b0},
        {1'b1, 4'd3,  5'd7,  5'd1,  16'h2000, 2'd1, 1'b0},
        {1'b0, 4'd15, 5'd30, 5'd31, 16'h0ffe, 2'd2, 1'b0},
        {1'b1, 4'd15, 5'd0,  5'd9,  16'h4000, 2'd0, 1'b1},
        {1'b0, 4'd1,  5'd5,  5'd4,  16'h0010, 2'd3, 1'b0},
        {1'b1, 4'd2,  5'd11, 5'd12, 16'h0002, 2'd0, 1'b1},
        {1'b0, 4'd0,  5'd3,  5'd6,  16'h0800, 2'd1, 1'b0},
        {1'b1, 4'd0,  5'd8,  5'd20, 16'h1234, 2'd0, 1'b1}
    };

    task automatic run_vec(input logic [33:0] v);
        logic        col;
        logic [3:0]  cnt;
        logic [4:0]  base, dst;
        logic [31:0] ptr;
        logic        spam;
        int b_rd, b_wb, b_done, b_bad, b_ov, guard, amiss;
        longint      sum;
        logic [31:0] exp_addr;
        col  = v[33];
        cnt  = v[32:29];
        base = v[28:24];
        dst  = v[23:19];
        ptr  = {16'h0, v[18:3]};
        lat  = int'(v[2:1]);
        spam = v[0];
        b_rd = rd_n; b_wb = wb_n; b_done = done_n; b_bad = bad_done; b_ov = overlap_n;

        @(negedge clk);
        cfg_ctrl = {col, cnt};
        mem_ptr  = ptr;
        src_base = base;
        dst_sel  = dst;
        start    = 1'b1;
        @(negedge clk);
        start = spam;
        if (spam) begin
            cfg_ctrl = ~{col, cnt};
            mem_ptr  = ~ptr;
            src_base = ~base;
            dst_sel  = ~dst;
        end
        guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        @(negedge clk);

        sum = 0;
        amiss = 0;
        for (int i = 0; i < int'(cnt); i++) begin
            logic [31:0] w;
            logic signed [15:0] e, m;
            w = rfval(5'(int'(base) + i / 2));
            e = (i % 2 == 0) ? w[31:16] : w[15:0];
            exp_addr = col ? ptr + 32'(i * 2 * int'(cnt)) : ptr + 32'(2 * i);
            m = memword(exp_addr);
            sum += longint'(e) * longint'(m);
            if (addr_log[(b_rd + i) % 256] !== exp_addr) amiss++;
        end

        chk(rd_n - b_rd == int'(cnt), cnt == 0 ? "R7 read count" : "R2 read count",
            rd_n - b_rd, cnt);
        if (cnt != 0)
            chk(amiss == 0, col ? "R4 column addresses" : "R3 row addresses", amiss, 0);
        chk(wb_last == sum[31:0], cnt == 0 ? "R7 zero result" : "R5 R6 result",
            wb_last, sum[31:0]);
        chk(wbi_last == dst && wb_n - b_wb == 1, "R9 write-back index/count",
            {wb_n - b_wb, wbi_last}, {1, dst});
        chk(done_n - b_done == 1 && bad_done == b_bad, "R9 done after write-back",
            done_n - b_done, 1);
        chk(overlap_n == b_ov, "R8 single outstanding read", overlap_n - b_ov, 0);
        if (spam) chk(wb_last == sum[31:0] && wbi_last == dst, "R10 start while busy",
            wb_last, sum[31:0]);
    endtask

    initial begin
        #(5.0 * 200000);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        start = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state, start held during reset
        chk(!busy && !mem_req && !wb_en && !done, "R1 in reset",
            {busy, mem_req, wb_en, done}, 0);
        start = 1'b0;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req && !wb_en && !done, "R1 after reset",
            {busy, mem_req, wb_en, done}, 0);
        chk(rd_n == 0 && wb_n == 0, "R1 no activity", rd_n + wb_n, 0);

        for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

        // directed: back-to-back starts, register index wrap with odd count
        run_vec({1'b0, 4'd3, 5'd31, 5'd0, 16'hfffe, 2'd0, 1'b0});
        run_vec({1'b1, 4'd7, 5'd29, 5'd17, 16'h8000, 2'd2, 1'b1});

        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !wb_en, "R1 idle at end",
            {busy, mem_req, wb_en}, 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule